// File: doc/BRIEF.md
# Backup Supply Select and Access Gate

This block chooses between the main supply and the backup battery and decides whether the host register interface may be used. It reads two comparator flags. One says the main supply is above the power-fail threshold. The other says the main supply is above the battery voltage. The battery is chosen only when both flags are low, so the switchover follows whichever threshold is lower. Each flag passes through a synchronizer before any decision is made.

Register access is closed whenever the battery is selected. After a battery episode, and after a battery power-on reset, access stays closed until the device's reset output line reads high again. The oscillator enable keeps the oscillator stopped after the battery is first attached. It starts only once the main supply has crossed the power-fail threshold at least once, and a sticky flag that only the battery power-on reset clears records that crossing. While on battery, a control bit can stop the oscillator.

Top module: `bkup_supply_gate`

## Requirements
- R1: While and right after reset (`rst` high), `use_battery_o` is 1, `bus_en_o` is 0 and `osc_en_o` is 0.
- R2: Each comparator flag passes through a 2-stage synchronizer. `use_battery_o` equals 1 exactly when both synchronized flags are 0, and it follows a change at the inputs after two rising clock edges.
- R3: `bus_en_o` is 0 in every cycle in which `use_battery_o` is 1.
- R4: After reset, or after any cycle with `use_battery_o` at 1, `bus_en_o` stays 0 while `rst_line_hi_i` is 0. It becomes 1 one clock edge after a cycle in which `use_battery_o` is 0 and `rst_line_hi_i` is 1.
- R5: With exactly one flag high (either one), the main supply stays selected and access opens under the rule of R4.
- R6: After a battery power-on reset, `osc_en_o` is 0 until the synchronized power-fail flag has been 1. It then becomes 1 one edge later, which is three edges after `main_gt_pf_i` rises.
- R7: The battery comparison flag alone never enables the oscillator for the first time.
- R8: Once the oscillator is enabled by a main-power crossing, later battery episodes and threshold drops do not clear that record. Only `rst` clears it.
- R9: Once main power has been seen, `osc_en_o` is 0 while `use_battery_o` and `osc_off_batt_i` are both 1, and 1 otherwise. `osc_off_batt_i` has no effect while the main supply is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high battery power-on reset |
| main_gt_pf_i | input | 1 | Comparator: main supply above power-fail threshold (asynchronous) |
| main_gt_bat_i | input | 1 | Comparator: main supply above battery voltage (asynchronous) |
| osc_off_batt_i | input | 1 | Control bit: stop the oscillator while on battery |
| rst_line_hi_i | input | 1 | Level of the reset output line, 1 = released |
| use_battery_o | output | 1 | 1 = battery selected, 0 = main supply selected |
| bus_en_o | output | 1 | Host register access allowed |
| osc_en_o | output | 1 | Oscillator enable |

## Verification
The main selection is tried with all four flag combinations. Both-low must pick the battery. The two single-high cases must keep the main supply, which shows the rule is an AND of the two comparisons and not a single threshold. Recovery is driven with the reset line held low and then released, which separates "off battery" from "access open". The oscillator path is driven first with only the battery comparison high, then with the power-fail comparison, then through a battery episode and a power-on reset. This tells the sticky first-crossing flag apart from a plain copy of the power-fail flag.

// File: rtl/supgate_pkg.sv
package supgate_pkg;

    typedef struct packed {
        logic above_pf;
        logic above_bat;
    } supply_flags_t;

    localparam int FLAG_W = $bits(supply_flags_t);

    typedef enum logic {
        GATE_CLOSED = 1'b0,
        GATE_OPEN   = 1'b1
    } gate_state_e;

    function automatic logic on_battery(supply_flags_t f);
        return !f.above_pf && !f.above_bat;
    endfunction

endpackage

// File: rtl/supgate_sync.sv
module supgate_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage_q[0] <= '0;
                    else     stage_q[0] <= d_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage_q[s] <= '0;
                    else     stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/supgate_decide.sv
module supgate_decide
    import supgate_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  supply_flags_t flags_i,
    input  logic          rst_line_hi_i,
    output logic          use_battery_o,
    output logic          bus_en_o
);
    gate_state_e gate_q;
    logic        batt;

    assign batt = on_battery(flags_i);

    always_ff @(posedge clk) begin
        if (rst)
            gate_q <= GATE_CLOSED;
        else if (batt)
            gate_q <= GATE_CLOSED;
        else if (rst_line_hi_i)
            gate_q <= GATE_OPEN;
    end

    assign use_battery_o = batt;
    assign bus_en_o      = (gate_q == GATE_OPEN) && !batt;

    // R4
    access_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_en_o) |-> $past(rst_line_hi_i));

    // R3
    access_blocked_batt_chk: assert property (@(posedge clk) disable iff (rst)
        use_battery_o |-> !bus_en_o);
endmodule

// File: rtl/supgate_osc.sv
module supgate_osc
    import supgate_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  supply_flags_t flags_i,
    input  logic          on_batt_i,
    input  logic          osc_off_batt_i,
    output logic          osc_en_o
);
    logic seen_q;

    always_ff @(posedge clk) begin
        if (rst)                  seen_q <= 1'b0;
        else if (flags_i.above_pf) seen_q <= 1'b1;
    end

    assign osc_en_o = seen_q && !(on_batt_i && osc_off_batt_i);

    // R8
    seen_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !$fell(seen_q));

    // R6
    seen_from_pf_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(seen_q) |-> $past(flags_i.above_pf));

    // R9
    osc_off_batt_chk: assert property (@(posedge clk) disable iff (rst)
        (on_batt_i && osc_off_batt_i) |-> !osc_en_o);
endmodule

// File: rtl/bkup_supply_gate.sv
module bkup_supply_gate
    import supgate_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic main_gt_pf_i,
    input  logic main_gt_bat_i,
    input  logic osc_off_batt_i,
    input  logic rst_line_hi_i,
    output logic use_battery_o,
    output logic bus_en_o,
    output logic osc_en_o
);
    supply_flags_t raw_flags;
    supply_flags_t sync_flags;
    logic [FLAG_W-1:0] sync_bits;

    assign raw_flags.above_pf  = main_gt_pf_i;
    assign raw_flags.above_bat = main_gt_bat_i;

    supgate_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (raw_flags),
        .q_o (sync_bits)
    );

    assign sync_flags = supply_flags_t'(sync_bits);

    supgate_decide u_decide (
        .clk           (clk),
        .rst           (rst),
        .flags_i       (sync_flags),
        .rst_line_hi_i (rst_line_hi_i),
        .use_battery_o (use_battery_o),
        .bus_en_o      (bus_en_o)
    );

    supgate_osc u_osc (
        .clk            (clk),
        .rst            (rst),
        .flags_i        (sync_flags),
        .on_batt_i      (use_battery_o),
        .osc_off_batt_i (osc_off_batt_i),
        .osc_en_o       (osc_en_o)
    );

    // R2
    batt_needs_both_low_chk: assert property (@(posedge clk) disable iff (rst)
        (main_gt_pf_i || main_gt_bat_i) |-> ##2 (!use_battery_o || !($past(main_gt_pf_i,2) || $past(main_gt_bat_i,2))));
endmodule

// File: tb/bkup_supply_gate_bench.sv
module bkup_supply_gate_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf = 1'b0, bat = 1'b0, osc_off = 1'b0, line_hi = 1'b0;
    logic use_batt, bus_en, osc_en;
    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    bkup_supply_gate u_bkup_supply_gate (
        .clk            (clk),
        .rst            (rst),
        .main_gt_pf_i   (pf),
        .main_gt_bat_i  (bat),
        .osc_off_batt_i (osc_off),
        .rst_line_hi_i  (line_hi),
        .use_battery_o  (use_batt),
        .bus_en_o       (bus_en),
        .osc_en_o       (osc_en)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1; pf = 0; bat = 0; osc_off = 0; line_hi = 0;
        step(3);
        check("R1", "use_battery in reset", use_batt, 1'b1);
        check("R1", "bus_en in reset", bus_en, 1'b0);
        check("R1", "osc_en in reset", osc_en, 1'b0);
        rst = 1'b0;
        step(1);
        check("R1", "osc_en after reset", osc_en, 1'b0);
    endtask

    task automatic t_first_attach();
        step(8);
        check("R6", "osc stays off before main seen", osc_en, 1'b0);
        line_hi = 1'b1;
        bat = 1'b1;
        step(1);
        check("R2", "battery kept before sync done", use_batt, 1'b1);
        step(1);
        check("R5", "main selected with only bat flag", use_batt, 1'b0);
        step(1);
        check("R5", "access opens with only bat flag", bus_en, 1'b1);
        step(5);
        check("R7", "bat flag alone no osc", osc_en, 1'b0);
    endtask

    task automatic t_pf_cross();
        pf = 1'b1;
        step(2);
        check("R6", "osc not yet on", osc_en, 1'b0);
        step(1);
        check("R6", "osc on after pf crossing", osc_en, 1'b1);
    endtask

    task automatic t_battery();
        pf = 0; bat = 0; osc_off = 0;
        step(1);
        check("R2", "main still selected one edge later", use_batt, 1'b0);
        step(1);
        check("R2", "battery selected both low", use_batt, 1'b1);
        check("R3", "no access on battery", bus_en, 1'b0);
        check("R9", "osc runs on battery, bit clear", osc_en, 1'b1);
        osc_off = 1'b1;
        step(1);
        check("R9", "osc stops on battery, bit set", osc_en, 1'b0);
    endtask

    task automatic t_recover();
        line_hi = 1'b0;
        pf = 1; bat = 1;
        step(3);
        check("R2", "main selected both high", use_batt, 1'b0);
        check("R9", "osc_off ignored on main", osc_en, 1'b1);
        step(5);
        check("R4", "access held while line low", bus_en, 1'b0);
        line_hi = 1'b1;
        #1;
        check("R4", "access not before edge", bus_en, 1'b0);
        step(1);
        check("R4", "access one edge after line high", bus_en, 1'b1);
    endtask

    task automatic t_pf_only();
        pf = 1; bat = 0;
        step(3);
        check("R5", "main selected with only pf flag", use_batt, 1'b0);
        check("R5", "access kept with only pf flag", bus_en, 1'b1);
    endtask

    task automatic t_sticky();
        osc_off = 1'b0;
        pf = 0; bat = 0;
        step(10);
        check("R3", "no access on battery again", bus_en, 1'b0);
        bat = 1'b1;
        step(4);
        check("R8", "osc still enabled after episode", osc_en, 1'b1);
        check("R4", "access reopens after episode", bus_en, 1'b1);
    endtask

    task automatic t_por();
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        check("R8", "reset clears osc enable", osc_en, 1'b0);
        step(6);
        check("R8", "osc stays off after por, bat only", osc_en, 1'b0);
        check("R5", "access open after por, bat only", bus_en, 1'b1);
    endtask

    initial begin
        t_reset();
        t_first_attach();
        t_pf_cross();
        t_battery();
        t_recover();
        t_pf_only();
        t_sticky();
        t_por();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule